// File: doc/BRIEF.md
# Processor Hot-Plug Presence Map and Event Status

This block belongs to a chipset power-management function. It holds one presence bit for each processor ID, 256 bits in all, laid out as a 32-byte map that the guest reads one byte at a time through an I/O window. A management-side request names a processor ID and says whether that processor was added or removed. The block then sets or clears the matching presence bit and latches a processor hot-plug bit in the general-purpose event status byte.

The event status byte also latches a PCI hot-plug event. Software clears its bits by writing ones to them. The block drives a level system control interrupt (SCI). The SCI is high while an enabled processor or PCI event bit is pending, or while the fixed-event term coming from the rest of the power-management logic is active.

At reset the block preloads the presence bits for the processors present at start-up: IDs 0 to INIT_CPUS-1. If that count does not fit the map, elaboration stops with an error.

Top module: `cpu_hotplug_gpe`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears gpe_sts, id_err and io_rdata, sets presence bits for IDs 0..INIT_CPUS-1 and clears all other presence bits.
- R2: A read (io_rd) at address BASE_ADDR+N, with N in 0..31, puts map byte N on io_rdata at the next clock edge. Processor k maps to bit k mod 8 of byte k div 8. The value returned is the state from before that edge. io_rdata holds its value while no read is issued.
- R3: A request with hp_valid high, hp_id below 256 and hp_plug=1 sets that processor's presence bit. With hp_plug=0 it clears that bit. The change is visible to a read issued in the following cycle.
- R4: Every accepted request, plug or unplug, sets gpe_sts bit 2 (value 0x04) at the next clock edge.
- R5: A pulse on pci_hp_evt sets gpe_sts bit 1 (value 0x02) at the next clock edge.
- R6: A write (io_wr) at STS_ADDR clears each gpe_sts bit whose io_wdata bit is 1. A read at STS_ADDR returns gpe_sts.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R8: sci is combinational and equals fixed_evt OR ((gpe_sts AND gpe_en AND 0x06) != 0).
- R9: Writes into the 32-byte map window do not change the presence map.
- R10: A request with hp_id of 256 or more is ignored: the map and gpe_sts do not change. It sets id_err, which stays high until reset.
- R11: A read at any address outside the map window and STS_ADDR returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_valid | input | 1 | Hot-plug request strobe |
| hp_id | input | 9 | Processor ID of the request |
| hp_plug | input | 1 | 1 = add processor, 0 = remove processor |
| pci_hp_evt | input | 1 | PCI hot-plug event pulse |
| gpe_en | input | 8 | Event enable byte |
| fixed_evt | input | 1 | Fixed-event status-and-enable term |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Byte read strobe |
| io_wr | input | 1 | Byte write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| gpe_sts | output | 8 | Event status byte |
| sci | output | 1 | Interrupt level |
| id_err | output | 1 | Sticky out-of-range ID flag |

## Verification
A wrong presence bit shows up only when the guest reads its byte. The bench therefore reads map bytes throughout the run, and a stale or misplaced bit appears on io_rdata one edge after the read. A wrong status bit shows on gpe_sts at the very next edge, and on sci in the same cycle whenever its enable bit is set. The bench compares every output on every clock against a behavioural model, so a divergence is caught in the cycle it first becomes visible.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
  localparam int GPE_PCI_BIT = 1;
  localparam int GPE_CPU_BIT = 2;
  localparam logic [7:0] GPE_SCI_MASK = 8'h06;
endpackage

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
  parameter int MAP_BYTES = 32,
  parameter int INIT_CPUS = 4,
  localparam int MAP_BITS = MAP_BYTES * 8,
  localparam int IDX_W = $clog2(MAP_BITS),
  localparam int BYTE_W = $clog2(MAP_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd_en,
  input  logic                upd_plug,
  input  logic [IDX_W-1:0]    upd_idx,
  input  logic [BYTE_W-1:0]   rd_byte,
  output logic [7:0]          rd_data,
  output logic [MAP_BITS-1:0] map_bits
);
  generate
    if (INIT_CPUS > MAP_BITS) begin : g_bad_init
      $error("start-up processor count exceeds presence map");
    end
  endgenerate

  function automatic logic [MAP_BITS-1:0] preload();
    logic [MAP_BITS-1:0] v;
    for (int i = 0; i < MAP_BITS; i++) v[i] = (i < INIT_CPUS);
    return v;
  endfunction

  localparam logic [MAP_BITS-1:0] PRELOAD = preload();

  logic [MAP_BITS-1:0] map_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= PRELOAD;
    end else if (upd_en) begin
      map_q[upd_idx] <= upd_plug;
    end
  end

  assign rd_data  = map_q[{rd_byte, 3'b000} +: 8];
  assign map_bits = map_q;
endmodule

// File: rtl/gpe_status_reg.sv
module gpe_status_reg
  import cpuhp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_evt,
  input  logic       pci_evt,
  input  logic       clr_we,
  input  logic [7:0] clr_mask,
  input  logic [7:0] gpe_en,
  input  logic       fixed_evt,
  output logic [7:0] sts_q,
  output logic       sci
);
  logic [7:0] set_vec;
  logic [7:0] clr_vec;

  always_comb begin
    set_vec = 8'h00;
    set_vec[GPE_CPU_BIT] = cpu_evt;
    set_vec[GPE_PCI_BIT] = pci_evt;
    clr_vec = clr_we ? clr_mask : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) sts_q <= 8'h00;
    else     sts_q <= (sts_q & ~clr_vec) | set_vec;
  end

  assign sci = fixed_evt | (|(sts_q & gpe_en & GPE_SCI_MASK));
endmodule

// File: rtl/cpu_hotplug_gpe.sv
module cpu_hotplug_gpe #(
  parameter int AW = 16,
  parameter int ID_W = 9,
  parameter int MAP_BYTES = 32,
  parameter int INIT_CPUS = 4,
  parameter logic [AW-1:0] BASE_ADDR = 16'hAF00,
  parameter logic [AW-1:0] STS_ADDR = 16'hAF20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hp_valid,
  input  logic [ID_W-1:0] hp_id,
  input  logic            hp_plug,
  input  logic            pci_hp_evt,
  input  logic [7:0]      gpe_en,
  input  logic            fixed_evt,
  input  logic [AW-1:0]   io_addr,
  input  logic            io_rd,
  input  logic            io_wr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  output logic [7:0]      gpe_sts,
  output logic            sci,
  output logic            id_err
);
  localparam int MAP_BITS = MAP_BYTES * 8;
  localparam int IDX_W = $clog2(MAP_BITS);
  localparam int BYTE_W = $clog2(MAP_BYTES);
  localparam logic [AW-1:0] MAP_SPAN = AW'(MAP_BYTES);

  logic [AW-1:0]       off;
  logic                in_map;
  logic                sts_hit;
  logic                hp_ok;
  logic                hp_bad;
  logic [7:0]          map_byte;
  logic [MAP_BITS-1:0] map_bits;

  assign off     = io_addr - BASE_ADDR;
  assign in_map  = off < MAP_SPAN;
  assign sts_hit = io_addr == STS_ADDR;
  assign hp_ok   = hp_valid && (int'(hp_id) < MAP_BITS);
  assign hp_bad  = hp_valid && !(int'(hp_id) < MAP_BITS);

  cpu_presence_map #(
    .MAP_BYTES(MAP_BYTES),
    .INIT_CPUS(INIT_CPUS)
  ) u_map (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (hp_ok),
    .upd_plug(hp_plug),
    .upd_idx (hp_id[IDX_W-1:0]),
    .rd_byte (off[BYTE_W-1:0]),
    .rd_data (map_byte),
    .map_bits(map_bits)
  );

  gpe_status_reg u_gpe (
    .clk      (clk),
    .rst      (rst),
    .cpu_evt  (hp_ok),
    .pci_evt  (pci_hp_evt),
    .clr_we   (io_wr && sts_hit),
    .clr_mask (io_wdata),
    .gpe_en   (gpe_en),
    .fixed_evt(fixed_evt),
    .sts_q    (gpe_sts),
    .sci      (sci)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= 8'h00;
      id_err   <= 1'b0;
    end else begin
      if (hp_bad) id_err <= 1'b1;
      if (io_rd) begin
        if (in_map)       io_rdata <= map_byte;
        else if (sts_hit) io_rdata <= gpe_sts;
        else              io_rdata <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/cpu_hotplug_gpe_chk.sv
module cpu_hotplug_gpe_chk #(
  parameter int AW = 16,
  parameter int ID_W = 9,
  parameter int MAP_BYTES = 32,
  parameter logic [AW-1:0] BASE_ADDR = 16'hAF00,
  parameter logic [AW-1:0] STS_ADDR = 16'hAF20
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   hp_valid,
  input logic [ID_W-1:0]        hp_id,
  input logic                   pci_hp_evt,
  input logic [7:0]             gpe_en,
  input logic                   fixed_evt,
  input logic [AW-1:0]          io_addr,
  input logic                   io_rd,
  input logic                   io_wr,
  input logic [7:0]             io_wdata,
  input logic [7:0]             io_rdata,
  input logic [7:0]             gpe_sts,
  input logic                   sci,
  input logic                   id_err,
  input logic [MAP_BYTES*8-1:0] map_bits
);
  localparam int MAP_BITS = MAP_BYTES * 8;
  logic win;
  logic sts_wr;
  assign win    = (io_addr >= BASE_ADDR) && ((io_addr - BASE_ADDR) < AW'(MAP_BYTES));
  assign sts_wr = io_wr && (io_addr == STS_ADDR);

  p_cpu_sts_set_r4: assert property (@(posedge clk) disable iff (rst)
    (hp_valid && int'(hp_id) < MAP_BITS) |=> gpe_sts[2]);

  p_pci_sts_set_r5: assert property (@(posedge clk) disable iff (rst)
    pci_hp_evt |=> gpe_sts[1]);

  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (hp_valid && int'(hp_id) < MAP_BITS && sts_wr && io_wdata[2]) |=> gpe_sts[2]);

  p_sci_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!fixed_evt && (gpe_en & 8'h06) == 8'h00) |-> !sci);

  p_map_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (io_wr && win && !hp_valid) |=> map_bits == $past(map_bits));

  p_bad_id_sts_r10: assert property (@(posedge clk) disable iff (rst)
    (hp_valid && int'(hp_id) >= MAP_BITS && !pci_hp_evt && !sts_wr)
      |=> gpe_sts == $past(gpe_sts));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    id_err |=> id_err);

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !win && io_addr != STS_ADDR) |=> io_rdata == 8'h00);
endmodule

bind cpu_hotplug_gpe cpu_hotplug_gpe_chk #(
  .AW(AW), .ID_W(ID_W), .MAP_BYTES(MAP_BYTES),
  .BASE_ADDR(BASE_ADDR), .STS_ADDR(STS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .hp_valid(hp_valid), .hp_id(hp_id),
  .pci_hp_evt(pci_hp_evt), .gpe_en(gpe_en), .fixed_evt(fixed_evt),
  .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .gpe_sts(gpe_sts), .sci(sci), .id_err(id_err),
  .map_bits(map_bits)
);

// File: tb/sim_cpu_hotplug_gpe.sv
`timescale 1ns/1ps
module sim_cpu_hotplug_gpe;
  localparam int INIT = 10;
  localparam logic [15:0] BASE = 16'hAF00;
  localparam logic [15:0] STS = 16'hAF20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hp_valid = 0, hp_plug = 0, pci_hp_evt = 0, fixed_evt = 0;
  logic io_rd = 0, io_wr = 0;
  logic [8:0] hp_id = '0;
  logic [7:0] gpe_en = '0, io_wdata = '0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_rdata, gpe_sts;
  logic sci, id_err;

  always #4 clk = ~clk;

  cpu_hotplug_gpe #(.INIT_CPUS(INIT)) u0 (
    .clk(clk), .rst(rst), .hp_valid(hp_valid), .hp_id(hp_id), .hp_plug(hp_plug),
    .pci_hp_evt(pci_hp_evt), .gpe_en(gpe_en), .fixed_evt(fixed_evt),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .gpe_sts(gpe_sts), .sci(sci), .id_err(id_err)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit ref_map [256];
  int ref_sts, ref_rd, ref_err;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_byte(input int n);
    int v = 0;
    for (int b = 0; b < 8; b++) if (ref_map[n*8+b]) v |= (1 << b);
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) ref_map[i] = (i < INIT);
    ref_sts = 0; ref_rd = 0; ref_err = 0;
  endtask

  task automatic model_edge();
    int a = int'(io_addr);
    int nsts = ref_sts;
    if (io_rd) begin
      if (a >= int'(BASE) && a < int'(BASE) + 32) ref_rd = ref_byte(a - int'(BASE));
      else if (a == int'(STS)) ref_rd = ref_sts;
      else ref_rd = 0;
    end
    if (io_wr && a == int'(STS)) nsts = nsts & ~int'(io_wdata);
    if (hp_valid && hp_id < 256) begin
      nsts |= 4;
      ref_map[hp_id] = hp_plug;
    end
    if (hp_valid && hp_id >= 256) ref_err = 1;
    if (pci_hp_evt) nsts |= 2;
    ref_sts = nsts & 8'hFF;
  endtask

  task automatic compare();
    int esci = (fixed_evt || ((ref_sts & int'(gpe_en) & 6) != 0)) ? 1 : 0;
    chk("R2/R3/R9/R11 io_rdata", int'(io_rdata), ref_rd);
    chk("R4/R5/R6/R7 gpe_sts", int'(gpe_sts), ref_sts);
    chk("R10 id_err", int'(id_err), ref_err);
    chk("R8 sci", int'(sci), esci);
  endtask

  task automatic step(input bit v, input int id, input bit plug, input bit pci,
                      input bit rd, input bit wr, input int a, input int wd);
    hp_valid = v; hp_id = 9'(id); hp_plug = plug; pci_hp_evt = pci;
    io_rd = rd; io_wr = wr; io_addr = 16'(a); io_wdata = 8'(wd);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input int a);
    step(0, 0, 0, 0, 1, 0, a, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 gpe_sts after reset", int'(gpe_sts), 0);
    chk("R1 id_err after reset", int'(id_err), 0);
    chk("R1 io_rdata after reset", int'(io_rdata), 0);
    rd(int'(BASE) + 0); chk("R1 byte0 preload", int'(io_rdata), 8'hFF);
    rd(int'(BASE) + 1); chk("R1 byte1 preload", int'(io_rdata), 8'h03);
    for (int n = 0; n < 32; n++) rd(int'(BASE) + n);   // R2 full sweep
    idle(); chk("R2 rdata holds", int'(io_rdata), 0);

    // R3/R4: plug and unplug
    step(1, 37, 1, 0, 0, 0, 0, 0);
    chk("R4 cpu bit after plug", int'(gpe_sts), 4);
    rd(int'(BASE) + 4); chk("R3 plug id37", int'(io_rdata), 8'h20);
    step(1, 255, 1, 0, 0, 0, 0, 0);
    rd(int'(BASE) + 31); chk("R3 plug id255", int'(io_rdata), 8'h80);
    step(1, 3, 0, 0, 1, 0, int'(BASE), 0);
    chk("R2 read sees pre-edge", int'(io_rdata), 8'hFF);
    rd(int'(BASE)); chk("R3 unplug id3", int'(io_rdata), 8'hF7);

    // R6 clear, R5 pci, R8 sci
    gpe_en = 8'h04;
    idle(); chk("R8 sci cpu enabled", int'(sci), 1);
    step(0, 0, 0, 0, 0, 1, int'(STS), 8'h04);
    chk("R6 w1c cpu", int'(gpe_sts), 0);
    chk("R8 sci low after clear", int'(sci), 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 pci bit", int'(gpe_sts), 2);
    chk("R8 pci masked", int'(sci), 0);
    gpe_en = 8'h02; idle(); chk("R8 pci enabled", int'(sci), 1);
    gpe_en = 8'hF9; idle(); chk("R8 other enables ignored", int'(sci), 0);
    fixed_evt = 1; idle(); chk("R8 fixed term", int'(sci), 1);
    fixed_evt = 0;
    rd(int'(STS)); chk("R6 read status", int'(io_rdata), 2);
    step(0, 0, 0, 0, 0, 1, int'(STS), 8'h01);
    chk("R6 w1c other bit", int'(gpe_sts), 2);

    // R7 race
    step(1, 40, 1, 1, 0, 1, int'(STS), 8'hFF);
    chk("R7 event wins clear", int'(gpe_sts), 6);
    step(0, 0, 0, 0, 0, 1, int'(STS), 8'hFF);

    // R9 writes to map ignored
    for (int n = 0; n < 32; n++) step(0, 0, 0, 0, 0, 1, int'(BASE) + n, 8'h5A);
    rd(int'(BASE) + 2); chk("R9 byte2 unchanged", int'(io_rdata), 0);
    rd(int'(BASE) + 5); chk("R9 byte5 unchanged", int'(io_rdata), 8'h01);

    // R10 bad ID
    step(1, 256, 1, 0, 0, 0, 0, 0);
    chk("R10 status unchanged", int'(gpe_sts), 0);
    chk("R10 err set", int'(id_err), 1);
    step(1, 511, 0, 0, 0, 0, 0, 0);
    rd(int'(BASE)); chk("R10 map unchanged", int'(io_rdata), 8'hF7);
    idle(); chk("R10 err sticky", int'(id_err), 1);

    // R11 unmapped
    rd(16'hAF40); chk("R11 unmapped", int'(io_rdata), 0);
    rd(int'(BASE) - 1); chk("R11 below base", int'(io_rdata), 0);

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      int sel = $urandom_range(0, 9);
      int a = (sel < 6) ? int'(BASE) + $urandom_range(0, 31)
            : (sel < 8) ? int'(STS) : int'($urandom_range(0, 16'hFFFF));
      gpe_en = 8'($urandom);
      fixed_evt = ($urandom_range(0, 7) == 0);
      step($urandom_range(0, 2) == 0, $urandom_range(0, 270), $urandom_range(0, 1),
           $urandom_range(0, 5) == 0, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
           a, $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule